// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block runs one DMA channel through a chain of transfer descriptors kept in memory. Software writes the address of the first descriptor, then sets the channel's start bit in a shared command word. The walker reads the descriptor's five 32-bit words through a single read port and loads the control, source, destination and count values it finds there. It then pulses a go strobe to the data mover and waits for that engine to report a result.

When the engine reports normal completion or an end-of-transfer request, the walker follows the next pointer if the descriptor's link bit is set, and otherwise returns to idle. An engine error ends the walk at once. Each descriptor carries its own enables for the three interrupt causes, and an enabled cause produces a one-cycle pulse on the interrupt output. The current descriptor address stays visible at all times, so software can find the remaining work after a halt and resume from it.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset the walker is idle: `sg_active`, `mem_req`, `xfer_go` and `irq` are all 0.
- R2: A command write starts a walk only when bit 31-CHAN (start) and bit 15-CHAN (write mask) are both 1. On the next cycle `sg_active` is 1 and `mem_addr` equals the head address. A start bit written with its mask bit clear does nothing.
- R3: Descriptor words are read at head, head+4, head+8, head+12 and head+16. They are, in this order: control, source, destination, control-and-count, next pointer. One cycle after the last word is accepted, `xfer_go` pulses for one cycle, with `xfer_ctrl`, `xfer_src`, `xfer_dst` and `xfer_count` (bits 15:0 of the control-and-count word) holding that descriptor's values.
- R4: `head_addr` shows the address of the descriptor being processed. After completion of a descriptor whose control-and-count bit 31 (link) is 1, the next pointer becomes the head and the next descriptor is fetched.
- R5: After completion of a descriptor whose link bit is 0, `sg_active` falls on the following cycle and no further descriptor is fetched.
- R6: `eng_done` raises `irq` for one cycle on the next cycle if control-and-count bit 29 is set, and leaves it low if that bit is clear.
- R7: `eng_eot` ends the current descriptor like `eng_done`, and raises `irq` if control-and-count bit 28 is set.
- R8: `eng_err` ends the walk on the next cycle even if the link bit is set. It raises `irq` only if control-and-count bit 27 is set. `head_addr` keeps the failing descriptor's address.
- R9: A command write with the mask bit 1 and the start bit 0 halts an active walk on the next cycle, whether fetching or waiting. No further `xfer_go` follows, and `head_addr` keeps the current descriptor, so a new start resumes there.
- R10: While a walk is active, a new start write and any `head_we` write are ignored.
- R11: A command write with the channel's mask bit clear does not halt an active walk.
- R12: Start and mask bits belonging to other channels neither start nor halt this channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: start bits 31:28, mask bits 15:12 |
| head_we | input | 1 | Head address write strobe (honoured while idle) |
| head_wdata | input | AW | New head address |
| head_addr | output | AW | Address of the current descriptor |
| sg_active | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request, held until accepted |
| mem_addr | output | AW | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 32 | Read data |
| xfer_go | output | 1 | One-cycle strobe: descriptor loaded, engine may start |
| xfer_ctrl | output | 32 | Loaded channel control word |
| xfer_src | output | AW | Loaded source address |
| xfer_dst | output | AW | Loaded destination address |
| xfer_count | output | CW | Loaded transfer count |
| eng_done | input | 1 | Engine reached terminal count |
| eng_eot | input | 1 | Engine saw an end-of-transfer request |
| eng_err | input | 1 | Engine reported an error |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench looks at what happens when a descriptor ends while its link bit is still set. An error must stop the chain there: a walker that checked the link bit before the error would fetch a descriptor that was never meant to run, and the scoreboard would see an `xfer_go` it did not expect. A halt is tested both in the middle of a fetch and while the engine is running, and the bench then checks that a restart picks up from the held head address; a design that advanced the head or cleared it would start at the wrong descriptor. A second start and a head write are issued in the middle of a run, where a careless design would begin fetching again or lose its place. The bench also flips each interrupt enable bit to catch a design that reads the wrong bit position, and it stalls the memory so that words arriving late still land in the right fields.

// File: rtl/sg_chain_walker.sv
module sg_chain_walker #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int CHAN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [31:0]   cmd_wdata,
  input  logic          head_we,
  input  logic [AW-1:0] head_wdata,
  output logic [AW-1:0] head_addr,
  output logic          sg_active,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          xfer_go,
  output logic [31:0]   xfer_ctrl,
  output logic [AW-1:0] xfer_src,
  output logic [AW-1:0] xfer_dst,
  output logic [CW-1:0] xfer_count,
  input  logic          eng_done,
  input  logic          eng_eot,
  input  logic          eng_err,
  output logic          irq
);
  localparam int START_BIT = 31 - CHAN;
  localparam int MASK_BIT  = 15 - CHAN;
  localparam int LINK_BIT  = 31;
  localparam int TC_EN     = 29;
  localparam int EOT_EN    = 28;
  localparam int ERR_EN    = 27;
  localparam int NWORDS    = 5;
  localparam int IW        = $clog2(NWORDS);
  localparam int WBYTES    = 4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN} state_t;

  state_t        state;
  logic [IW-1:0] widx;
  logic [AW-1:0] head_q, src_q, dst_q, next_q;
  logic [31:0]   ctrl_q, cc_q;
  logic          go_q, irq_q;

  wire start_wr = cmd_we && cmd_wdata[MASK_BIT] &&  cmd_wdata[START_BIT];
  wire stop_wr  = cmd_we && cmd_wdata[MASK_BIT] && !cmd_wdata[START_BIT];
  wire accept   = mem_req && mem_rvalid;
  wire last_wd  = (widx == IW'(NWORDS - 1));
  wire unused_bits = ^{cmd_wdata, cc_q, mem_rdata};

  assign sg_active  = (state != S_IDLE);
  assign mem_req    = (state == S_FETCH);
  assign mem_addr   = head_q + AW'(widx) * AW'(WBYTES);
  assign head_addr  = head_q;
  assign xfer_go    = go_q;
  assign xfer_ctrl  = ctrl_q;
  assign xfer_src   = src_q;
  assign xfer_dst   = dst_q;
  assign xfer_count = cc_q[CW-1:0];
  assign irq        = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      widx   <= '0;
      head_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      next_q <= '0;
      ctrl_q <= '0;
      cc_q   <= '0;
      go_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      go_q  <= 1'b0;
      irq_q <= 1'b0;
      if (head_we && state == S_IDLE) head_q <= head_wdata;
      unique case (state)
        S_IDLE: begin
          widx <= '0;
          if (start_wr) state <= S_FETCH;
        end
        S_FETCH: begin
          if (stop_wr) begin
            state <= S_IDLE;
          end else if (accept) begin
            unique case (widx)
              IW'(0): ctrl_q <= mem_rdata;
              IW'(1): src_q  <= mem_rdata[AW-1:0];
              IW'(2): dst_q  <= mem_rdata[AW-1:0];
              IW'(3): cc_q   <= mem_rdata;
              default: next_q <= mem_rdata[AW-1:0];
            endcase
            if (last_wd) begin
              state <= S_RUN;
              go_q  <= 1'b1;
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        S_RUN: begin
          if (stop_wr) begin
            state <= S_IDLE;
          end else if (eng_err) begin
            irq_q <= cc_q[ERR_EN];
            state <= S_IDLE;
          end else if (eng_eot || eng_done) begin
            irq_q <= eng_eot ? cc_q[EOT_EN] : cc_q[TC_EN];
            if (cc_q[LINK_BIT]) begin
              head_q <= next_q;
              widx   <= '0;
              state  <= S_FETCH;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic          start_bit,
  input logic          mask_bit,
  input logic          head_we,
  input logic [AW-1:0] head_addr,
  input logic          sg_active,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          xfer_go,
  input logic          eng_done,
  input logic          eng_eot,
  input logic          eng_err,
  input logic          irq
);
  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sg_active |-> (!mem_req && !xfer_go));

  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sg_active && !(cmd_we && mask_bit && start_bit)) |=> !sg_active);

  p_go_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> $past(mem_req && mem_rvalid));

  p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);

  p_head_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_active && $past(sg_active) && !$stable(head_addr)) |-> $past(eng_done || eng_eot));

  p_head_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_active && head_we && !(eng_done || eng_eot)) |=> $stable(head_addr));

  p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_active && !mem_req && !xfer_go && eng_err) |=> !sg_active);

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_active && cmd_we && mask_bit && !start_bit) |=> (!sg_active && !xfer_go));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(eng_done || eng_eot || eng_err));
endmodule

bind sg_chain_walker sgw_checker #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .start_bit  (cmd_wdata[31 - CHAN]),
  .mask_bit   (cmd_wdata[15 - CHAN]),
  .head_we    (head_we),
  .head_addr  (head_addr),
  .sg_active  (sg_active),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .xfer_go    (xfer_go),
  .eng_done   (eng_done),
  .eng_eot    (eng_eot),
  .eng_err    (eng_err),
  .irq        (irq)
);

// File: tb/sg_chain_walker_tb_top.sv
`timescale 1ns/1ps
module sg_chain_walker_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic head_we = 1'b0;
  logic [AW-1:0] head_wdata = '0;
  logic [AW-1:0] head_addr, mem_addr, xfer_src, xfer_dst;
  logic sg_active, mem_req, xfer_go, irq;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] xfer_ctrl;
  logic [CW-1:0] xfer_count;
  logic eng_done = 1'b0, eng_eot = 1'b0, eng_err = 1'b0;

  always #2.5 clk = ~clk;

  sg_chain_walker #(.AW(AW), .CW(CW), .CHAN(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .head_we(head_we), .head_wdata(head_wdata), .head_addr(head_addr),
    .sg_active(sg_active), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .xfer_go(xfer_go),
    .xfer_ctrl(xfer_ctrl), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_count(xfer_count), .eng_done(eng_done), .eng_eot(eng_eot),
    .eng_err(eng_err), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] c;
    logic [31:0] s;
    logic [31:0] d;
    logic [15:0] n;
  } item_t;

  item_t exp_q[$];
  logic [31:0] mem [0:63];
  int n_chk = 0;
  int n_err = 0;
  bit stall_en = 1'b0;
  logic [7:0] cyc = '0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 8'd1;

  always @(negedge clk) begin
    mem_rvalid <= mem_req && !(stall_en && cyc[1:0] == 2'd1);
    mem_rdata  <= mem[mem_addr[7:2]];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && xfer_go) begin
      if (exp_q.size() == 0) begin
        chk("R3", "unexpected xfer_go", 32'd1, 32'd0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk("R3", "ctrl", xfer_ctrl, e.c);
        chk("R3", "src", xfer_src, e.s);
        chk("R3", "dst", xfer_dst, e.d);
        chk("R3", "count", {16'd0, xfer_count}, {16'd0, e.n});
      end
    end
  end

  task automatic put_desc(input int base, input logic [31:0] c, s, d, cc, nx);
    mem[base/4]     = c;
    mem[base/4 + 1] = s;
    mem[base/4 + 2] = d;
    mem[base/4 + 3] = cc;
    mem[base/4 + 4] = nx;
  endtask

  task automatic expect_desc(input int base);
    item_t e;
    e.c = mem[base/4];
    e.s = mem[base/4 + 1];
    e.d = mem[base/4 + 2];
    e.n = mem[base/4 + 3][15:0];
    exp_q.push_back(e);
  endtask

  task automatic cmd_write(input logic [31:0] d);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic set_head(input logic [31:0] a);
    @(negedge clk); head_we = 1'b1; head_wdata = a;
    @(negedge clk); head_we = 1'b0;
  endtask

  task automatic wait_go(input string req);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (xfer_go) seen = 1'b1;
    end
    chk(req, "xfer_go seen", {31'd0, seen}, 32'd1);
  endtask

  task automatic respond(input int kind, input int dly);
    repeat (dly) @(negedge clk);
    case (kind)
      0: eng_done = 1'b1;
      1: eng_eot  = 1'b1;
      default: eng_err = 1'b1;
    endcase
    @(negedge clk);
    eng_done = 1'b0; eng_eot = 1'b0; eng_err = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put_desc(32'h00, 32'hC000_0001, 32'h1000_0000, 32'h2000_0000, 32'hA000_0010, 32'h20);
    put_desc(32'h20, 32'hC000_0002, 32'h1000_0100, 32'h2000_0100, 32'h8000_0002, 32'h40);
    put_desc(32'h40, 32'hC000_0003, 32'h1000_0200, 32'h2000_0200, 32'h1000_FFFF, 32'h0);
    put_desc(32'h60, 32'h8000_0004, 32'h3000_0000, 32'h4000_0000, 32'h8800_0005, 32'h80);
    put_desc(32'h80, 32'h8000_0005, 32'h3000_0100, 32'h4000_0100, 32'h0000_0001, 32'h0);
    put_desc(32'hA0, 32'h8000_0006, 32'h5000_0000, 32'h6000_0000, 32'h8000_0003, 32'h80);
    put_desc(32'hC0, 32'h8000_0007, 32'h7000_0000, 32'h7800_0000, 32'h8000_0007, 32'hE0);
    put_desc(32'hE0, 32'h8000_0008, 32'h7000_0100, 32'h7800_0100, 32'h2000_0001, 32'h0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sg_active", {31'd0, sg_active}, 32'd0);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1", "xfer_go", {31'd0, xfer_go}, 32'd0);
    chk("R1", "irq", {31'd0, irq}, 32'd0);

    set_head(32'h00);
    cmd_write(32'h4000_4000);
    chk("R12", "other channel start", {31'd0, sg_active}, 32'd0);
    cmd_write(32'h8000_0000);
    chk("R2", "start without mask", {31'd0, sg_active}, 32'd0);

    // three-descriptor chain with memory stalls
    stall_en = 1'b1;
    expect_desc(32'h00); expect_desc(32'h20); expect_desc(32'h40);
    cmd_write(32'h8000_8000);
    chk("R2", "active after start", {31'd0, sg_active}, 32'd1);
    chk("R2", "first read addr", mem_addr, 32'h00);
    wait_go("R3");
    chk("R4", "head of desc0", head_addr, 32'h00);
    respond(0, 2);
    chk("R6", "tc irq enabled", {31'd0, irq}, 32'd1);
    wait_go("R4");
    chk("R4", "head follows link", head_addr, 32'h20);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 32'h8000_8000; head_we = 1'b1; head_wdata = 32'h3C;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0; head_we = 1'b0;
    chk("R10", "head kept", head_addr, 32'h20);
    chk("R10", "still running", {31'd0, sg_active}, 32'd1);
    chk("R10", "no refetch", {31'd0, mem_req}, 32'd0);
    respond(0, 1);
    chk("R6", "tc irq disabled", {31'd0, irq}, 32'd0);
    wait_go("R4");
    chk("R4", "head of desc2", head_addr, 32'h40);
    respond(1, 3);
    chk("R7", "eot irq", {31'd0, irq}, 32'd1);
    chk("R5", "walk ended", {31'd0, sg_active}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R5", "no fetch after last", {31'd0, mem_req}, 32'd0);
    stall_en = 1'b0;

    // error with link set, interrupt enabled
    set_head(32'h60);
    expect_desc(32'h60);
    cmd_write(32'h8000_8000);
    wait_go("R8");
    respond(2, 2);
    chk("R8", "err irq enabled", {31'd0, irq}, 32'd1);
    chk("R8", "stopped on error", {31'd0, sg_active}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R8", "head kept after error", head_addr, 32'h60);

    // error with interrupt disabled
    set_head(32'hA0);
    expect_desc(32'hA0);
    cmd_write(32'h8000_8000);
    wait_go("R8");
    respond(2, 1);
    chk("R8", "err irq disabled", {31'd0, irq}, 32'd0);
    chk("R8", "stopped on error 2", {31'd0, sg_active}, 32'd0);

    // halt while engine runs
    set_head(32'hC0);
    expect_desc(32'hC0);
    cmd_write(32'h8000_8000);
    wait_go("R9");
    cmd_write(32'h0000_0000);
    chk("R11", "no halt without mask", {31'd0, sg_active}, 32'd1);
    cmd_write(32'h0000_4000);
    chk("R12", "other channel halt", {31'd0, sg_active}, 32'd1);
    cmd_write(32'h0000_8000);
    chk("R9", "halted", {31'd0, sg_active}, 32'd0);
    chk("R9", "head kept", head_addr, 32'hC0);
    repeat (10) @(negedge clk);

    // restart resumes at held head, then halt mid-fetch
    cmd_write(32'h8000_8000);
    chk("R9", "resume address", mem_addr, 32'hC0);
    @(negedge clk);
    cmd_write(32'h0000_8000);
    chk("R9", "halt during fetch", {31'd0, sg_active}, 32'd0);
    chk("R9", "no request after halt", {31'd0, mem_req}, 32'd0);
    repeat (10) @(negedge clk);

    // full resume to the end
    expect_desc(32'hC0); expect_desc(32'hE0);
    cmd_write(32'h8000_8000);
    wait_go("R9");
    respond(0, 1);
    chk("R6", "no tc irq", {31'd0, irq}, 32'd0);
    wait_go("R4");
    chk("R4", "head second", head_addr, 32'hE0);
    respond(0, 1);
    chk("R6", "tc irq last", {31'd0, irq}, 32'd1);
    chk("R5", "ended", {31'd0, sg_active}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R3", "scoreboard drained", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule